// File: doc/BRIEF.md
# Serial Multiturn Word Reader

This block is a synchronous serial master that fetches one binary turn-count word from an external absolute sensor. It generates the serial clock and samples the returned data line. A 4-bit layout code sets how the word is split: a singleturn fragment only, a singleturn fragment followed by a 12-bit turn count, or a pure turn count. A 2-bit selector adds one to four trailing synchronization bits. Every accepted read produces one frame. The frame opens with an acknowledge pulse, carries the payload MSB first, and ends with the clock held high for a fixed idle timeout.

A read is launched by a start strobe, normally once after power-up. When the acknowledge level or the end-of-frame line level is wrong, the block raises its error flag and repeats the frame at once, up to a parameterised number of times. The first clean word is split into turn-count, singleturn and synchronization fields. It is loaded into the output registers with a one-cycle valid strobe, which is meant to preset a downstream period counter.

Top module: `mt_word_reader`

## Requirements
- R1: With layout code 0 a start strobe is ignored: `sclk_o` stays high, `valid_o` stays low and `err_o` keeps its value.
- R2: The payload length is set by the layout code: codes 1..6 give that many singleturn bits, codes 7..10 give (code-4) singleturn bits plus 12 turn bits, codes 11..14 give 4, 8, 12 or 16 turn bits, and code 15 gives 18 turn bits. The synchronization length is `sync_sel_i`+1. The frame length N is the sum of the payload length and the synchronization length.
- R3: `sclk_o` idles high. One cycle after an accepted start it falls. It then makes N+1 pulses, each low for HALF_CYC cycles and then high for HALF_CYC cycles.
- R4: The rising edge that ends the first pulse samples an acknowledge bit, which must be 0. The next N rising edges sample the payload, MSB first.
- R5: The payload fields are taken from the received word in this order: the first bits received go to `mt_o`, the next bits to `st_o`, and the last `sync_sel_i`+1 bits to `sync_o`. Each field is right-aligned and zero-filled.
- R6: After the last pulse `sclk_o` stays high for TOUT_CYC cycles. The data line is then sampled and must be 1.
- R7: A clean frame gives a one-cycle `valid_o` at the end of the timeout. The fields update in that same cycle and hold until the next clean frame.
- R8: A frame with a high acknowledge or a low end level sets `err_o` at the end of its timeout. In that same cycle `sclk_o` goes low to start a repeat, for up to MAX_RETRY repeats.
- R9: If all MAX_RETRY repeats fail, `sclk_o` returns high and stays high, `err_o` stays 1, no `valid_o` is given, and the fields keep their previous values.
- R10: An accepted start clears `err_o` in the next cycle. A start strobe that arrives while a read is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 4 | Word layout code |
| sync_sel_i | input | 2 | Synchronization length minus one |
| start_i | input | 1 | Read request strobe |
| sclk_o | output | 1 | Serial clock to the sensor |
| sdata_i | input | 1 | Serial data from the sensor |
| mt_o | output | 18 | Turn-count field |
| st_o | output | 6 | Singleturn field |
| sync_o | output | 4 | Synchronization field |
| valid_o | output | 1 | One-cycle strobe on a clean word |
| err_o | output | 1 | Communication error flag |

## Verification
The embedded properties assume two things. First, `sdata_i` is steady at the system clock edges where the serial clock rises and at the end of the timeout. Second, the layout code and selector matter only in the cycle a start is accepted. The bench sensor model meets both conditions. It changes the data line only on the falling system-clock edge after it sees `sclk_o` fall. It restores the idle level a few cycles into the final high phase, well inside the timeout. Faults are injected per frame through acknowledge and end-level masks, so each repeat of a read can be made to pass or fail on its own.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

    localparam int ST_MAX    = 6;
    localparam int MT_MAX    = 18;
    localparam int SYNC_MAX  = 4;
    localparam int FRAME_MAX = MT_MAX + SYNC_MAX;
    localparam int CNT_W     = $clog2(FRAME_MAX + 2);

    typedef struct packed {
        logic       active;
        logic [2:0] st_len;
        logic [4:0] mt_len;
        logic [2:0] sync_len;
    } layout_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LOW,
        SEQ_HIGH,
        SEQ_TOUT
    } seq_state_t;

    function automatic layout_t decode_layout(input logic [3:0] mode,
                                              input logic [1:0] sel);
        layout_t l;
        l.active   = 1'b1;
        l.st_len   = 3'd0;
        l.mt_len   = 5'd0;
        l.sync_len = 3'(sel) + 3'd1;
        case (mode)
            4'h0: l.active = 1'b0;
            4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6: l.st_len = mode[2:0];
            4'h7, 4'h8, 4'h9, 4'hA: begin
                l.st_len = 3'(mode - 4'd4);
                l.mt_len = 5'd12;
            end
            4'hB: l.mt_len = 5'd4;
            4'hC: l.mt_len = 5'd8;
            4'hD: l.mt_len = 5'd12;
            4'hE: l.mt_len = 5'd16;
            default: l.mt_len = 5'd18;
        endcase
        return l;
    endfunction

    function automatic logic [CNT_W-1:0] frame_len(input layout_t l);
        return CNT_W'(l.st_len) + CNT_W'(l.mt_len) + CNT_W'(l.sync_len);
    endfunction

endpackage

// File: rtl/mtr_shift_in.sv
module mtr_shift_in #(
    parameter int WIDTH = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             shift_i,
    input  logic             din_i,
    output logic [WIDTH-1:0] word_o
);

    logic [WIDTH-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            sr_q <= '0;
        end else if (shift_i) begin
            sr_q <= {sr_q[WIDTH-2:0], din_i};
        end
    end

    assign word_o = sr_q;

endmodule

// File: rtl/mtr_field_split.sv
module mtr_field_split
    import mtr_pkg::*;
(
    input  logic [FRAME_MAX-1:0] frame_i,
    input  layout_t              layout_i,
    output logic [SYNC_MAX-1:0]  sync_o,
    output logic [ST_MAX-1:0]    st_o,
    output logic [MT_MAX-1:0]    mt_o
);

    logic [FRAME_MAX-1:0] past_sync;
    logic [FRAME_MAX-1:0] past_st;

    always_comb begin
        past_sync = frame_i >> layout_i.sync_len;
        past_st   = past_sync >> layout_i.st_len;
    end

    genvar gi;
    generate
        for (gi = 0; gi < SYNC_MAX; gi++) begin : g_sync
            assign sync_o[gi] = frame_i[gi] && (32'(gi) < 32'(layout_i.sync_len));
        end
        for (gi = 0; gi < ST_MAX; gi++) begin : g_st
            assign st_o[gi] = past_sync[gi] && (32'(gi) < 32'(layout_i.st_len));
        end
        for (gi = 0; gi < MT_MAX; gi++) begin : g_mt
            assign mt_o[gi] = past_st[gi] && (32'(gi) < 32'(layout_i.mt_len));
        end
    endgenerate

endmodule

// File: rtl/mtr_seq.sv
module mtr_seq
    import mtr_pkg::*;
#(
    parameter int HALF_CYC  = 4,
    parameter int TOUT_CYC  = 20,
    parameter int MAX_RETRY = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start_i,
    input  logic    sdata_i,
    input  layout_t layout_i,
    output logic    sclk_o,
    output logic    shift_o,
    output logic    clear_o,
    output logic    accept_o,
    output logic    err_o,
    output layout_t layout_o
);

    localparam int TIM_MAX = (HALF_CYC > TOUT_CYC) ? HALF_CYC : TOUT_CYC;
    localparam int TIM_W   = $clog2(TIM_MAX + 1);
    localparam int RTY_W   = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;

    seq_state_t       state_q;
    logic [TIM_W-1:0] timer_q;
    logic [CNT_W-1:0] idx_q;
    logic [RTY_W-1:0] tries_q;
    logic             ack_bad_q;
    logic             err_q;
    layout_t          lay_q;

    logic             half_end;
    logic             tout_end;
    logic             line_good;
    logic [CNT_W-1:0] flen;

    always_comb begin
        half_end  = (timer_q == TIM_W'(HALF_CYC - 1));
        tout_end  = (timer_q == TIM_W'(TOUT_CYC - 1));
        line_good = !ack_bad_q && sdata_i;
        flen      = frame_len(lay_q);
        sclk_o    = (state_q != SEQ_LOW);
        shift_o   = (state_q == SEQ_LOW) && half_end && (idx_q != '0);
        clear_o   = (state_q == SEQ_LOW) && (idx_q == '0);
        accept_o  = (state_q == SEQ_TOUT) && tout_end && line_good;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SEQ_IDLE;
            timer_q   <= '0;
            idx_q     <= '0;
            tries_q   <= '0;
            ack_bad_q <= 1'b0;
            err_q     <= 1'b0;
            lay_q     <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start_i && layout_i.active) begin
                        lay_q     <= layout_i;
                        state_q   <= SEQ_LOW;
                        timer_q   <= '0;
                        idx_q     <= '0;
                        tries_q   <= '0;
                        ack_bad_q <= 1'b0;
                        err_q     <= 1'b0;
                    end
                end
                SEQ_LOW: begin
                    if (half_end) begin
                        timer_q <= '0;
                        state_q <= SEQ_HIGH;
                        if (idx_q == '0) begin
                            ack_bad_q <= sdata_i;
                        end
                        idx_q <= idx_q + CNT_W'(1);
                    end else begin
                        timer_q <= timer_q + TIM_W'(1);
                    end
                end
                SEQ_HIGH: begin
                    if (half_end) begin
                        timer_q <= '0;
                        if (idx_q == flen + CNT_W'(1)) begin
                            state_q <= SEQ_TOUT;
                        end else begin
                            state_q <= SEQ_LOW;
                        end
                    end else begin
                        timer_q <= timer_q + TIM_W'(1);
                    end
                end
                default: begin
                    if (tout_end) begin
                        timer_q <= '0;
                        if (line_good) begin
                            state_q <= SEQ_IDLE;
                        end else begin
                            err_q <= 1'b1;
                            if (tries_q < RTY_W'(MAX_RETRY)) begin
                                tries_q   <= tries_q + RTY_W'(1);
                                state_q   <= SEQ_LOW;
                                idx_q     <= '0;
                                ack_bad_q <= 1'b0;
                            end else begin
                                state_q <= SEQ_IDLE;
                            end
                        end
                    end else begin
                        timer_q <= timer_q + TIM_W'(1);
                    end
                end
            endcase
        end
    end

    assign err_o    = err_q;
    assign layout_o = lay_q;

    // R1: an inactive layout code never leaves idle
    a_r1_inactive_stays_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_IDLE && !layout_i.active) |=> (state_q == SEQ_IDLE));

    // R3: the timeout is entered only after N+1 pulses
    a_r3_pulse_count: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_TOUT) |-> (idx_q == flen + CNT_W'(1)));

    // R8: repeats never exceed the limit
    a_r8_retry_bound: assert property (@(posedge clk) disable iff (rst)
        (32'(tries_q) <= MAX_RETRY));

    // R9: exhausted repeats end idle with the error kept
    a_r9_exhausted_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_TOUT && tout_end && !line_good && tries_q == RTY_W'(MAX_RETRY))
        |=> (state_q == SEQ_IDLE && err_o));

    // R10: an accepted start clears the error flag
    a_r10_start_clears_err: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_IDLE && start_i && layout_i.active) |=> !err_o);

endmodule

// File: rtl/mt_word_reader.sv
module mt_word_reader
    import mtr_pkg::*;
#(
    parameter int HALF_CYC  = 4,
    parameter int TOUT_CYC  = 20,
    parameter int MAX_RETRY = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [3:0]          mode_i,
    input  logic [1:0]          sync_sel_i,
    input  logic                start_i,
    output logic                sclk_o,
    input  logic                sdata_i,
    output logic [MT_MAX-1:0]   mt_o,
    output logic [ST_MAX-1:0]   st_o,
    output logic [SYNC_MAX-1:0] sync_o,
    output logic                valid_o,
    output logic                err_o
);

    layout_t              req_layout;
    layout_t              run_layout;
    logic                 shift_w;
    logic                 clear_w;
    logic                 accept_w;
    logic [FRAME_MAX-1:0] frame_w;
    logic [MT_MAX-1:0]    mt_w;
    logic [ST_MAX-1:0]    st_w;
    logic [SYNC_MAX-1:0]  sync_w;

    assign req_layout = decode_layout(mode_i, sync_sel_i);

    mtr_seq #(
        .HALF_CYC  (HALF_CYC),
        .TOUT_CYC  (TOUT_CYC),
        .MAX_RETRY (MAX_RETRY)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .sdata_i  (sdata_i),
        .layout_i (req_layout),
        .sclk_o   (sclk_o),
        .shift_o  (shift_w),
        .clear_o  (clear_w),
        .accept_o (accept_w),
        .err_o    (err_o),
        .layout_o (run_layout)
    );

    mtr_shift_in #(
        .WIDTH (FRAME_MAX)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .clear_i (clear_w),
        .shift_i (shift_w),
        .din_i   (sdata_i),
        .word_o  (frame_w)
    );

    mtr_field_split u_split (
        .frame_i  (frame_w),
        .layout_i (run_layout),
        .sync_o   (sync_w),
        .st_o     (st_w),
        .mt_o     (mt_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            mt_o    <= '0;
            st_o    <= '0;
            sync_o  <= '0;
        end else begin
            valid_o <= accept_w;
            if (accept_w) begin
                mt_o   <= mt_w;
                st_o   <= st_w;
                sync_o <= sync_w;
            end
        end
    end

    // R7: valid is a single-cycle strobe
    a_r7_valid_single: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R6: a word is delivered only when the end level was high
    a_r6_end_line_high: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(sdata_i));

    // R7: fields change only together with valid
    a_r7_fields_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(mt_o) && $stable(st_o) && $stable(sync_o)));

endmodule

// File: tb/mt_word_reader_bench.sv
module mt_word_reader_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int TOUT       = 20;
    localparam int RETRY      = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  mode_r = 4'h0;
    logic [1:0]  sel_r = 2'd0;
    logic        start_r = 1'b0;
    logic        sdata_r = 1'b1;
    logic        sclk;
    logic [17:0] mt;
    logic [5:0]  st;
    logic [3:0]  sy;
    logic        valid;
    logic        err;

    int vectors = 0;
    int fails = 0;
    int last_mt = 0;
    int last_st = 0;
    int last_sy = 0;

    int sens_word = 0;
    int sens_len = 0;
    int sens_ack = 0;
    int sens_end = 0;
    int sens_att = 0;
    int sens_k = 0;
    int hi_cnt = 0;
    logic sclk_prev = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    mt_word_reader #(
        .HALF_CYC  (HALF),
        .TOUT_CYC  (TOUT),
        .MAX_RETRY (RETRY)
    ) u_mt_word_reader (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode_r),
        .sync_sel_i (sel_r),
        .start_i    (start_r),
        .sclk_o     (sclk),
        .sdata_i    (sdata_r),
        .mt_o       (mt),
        .st_o       (st),
        .sync_o     (sy),
        .valid_o    (valid),
        .err_o      (err)
    );

    // sensor model: reacts to serial clock falls, idles high after a frame
    always @(negedge clk) begin
        if (sclk_prev && !sclk) begin
            if (sens_k == 0) sdata_r = ((sens_ack >> sens_att) & 1) != 0;
            else sdata_r = ((sens_word >> (sens_len - sens_k)) & 1) != 0;
            sens_k++;
            hi_cnt = 0;
        end else if (sclk) begin
            hi_cnt++;
            if (hi_cnt == HALF + 3 && sens_k != 0) begin
                sdata_r = ((sens_end >> sens_att) & 1) == 0;
                sens_att++;
                sens_k = 0;
            end
        end
        sclk_prev = sclk;
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic void ref_layout(input int mode, output int stl, output int mtl);
        stl = 0;
        mtl = 0;
        if (mode >= 1 && mode <= 6) stl = mode;
        else if (mode >= 7 && mode <= 10) begin stl = mode - 4; mtl = 12; end
        else if (mode >= 11 && mode <= 14) mtl = 4 * (mode - 10);
        else if (mode == 15) mtl = 18;
    endfunction

    task automatic check_fields(input string tag);
        check(tag, "mt_o", int'(mt), last_mt);
        check(tag, "st_o", int'(st), last_st);
        check(tag, "sync_o", int'(sy), last_sy);
    endtask

    task automatic run_read(input int mode, input int sel, input int word,
                            input int ack_m, input int end_m, input int restart_s,
                            input bit err_before, input string tag);
        int stl, mtl, sl, n, len_l, s0, bad;
        bit done, err_exp;
        ref_layout(mode, stl, mtl);
        sl = sel + 1;
        n = stl + mtl + sl;
        len_l = (n + 1) * 2 * HALF + TOUT;
        sens_word = word;
        sens_len = n;
        sens_ack = ack_m;
        sens_end = end_m;
        sens_att = 0;
        @(negedge clk);
        mode_r = 4'(mode);
        sel_r = 2'(sel);
        start_r = 1'b1;
        err_exp = 1'b0;
        s0 = 0;
        done = 1'b0;
        if (err_before) check(tag, "err_o before start", int'(err), 1);
        for (int att = 0; att <= RETRY && !done; att++) begin
            for (int s = s0; s < len_l; s++) begin
                step();
                start_r = (att == 0 && s == restart_s);
                check(tag, "sclk_o", int'(sclk),
                      int'(((s / HALF) % 2 == 1) || (s >= (n + 1) * 2 * HALF)));
                check(tag, "valid_o", int'(valid), 0);
                check(tag, "err_o", int'(err), int'(err_exp));
            end
            step();
            start_r = 1'b0;
            bad = ((ack_m >> att) & 1) | ((end_m >> att) & 1);
            if (bad == 0) begin
                last_sy = word & ((1 << sl) - 1);
                last_st = (word >> sl) & ((1 << stl) - 1);
                last_mt = (word >> (sl + stl)) & ((1 << mtl) - 1);
                check(tag, "valid_o at end", int'(valid), 1);
                check(tag, "sclk_o at end", int'(sclk), 1);
                check(tag, "err_o at end", int'(err), int'(err_exp));
                check_fields(tag);
                done = 1'b1;
            end else begin
                err_exp = 1'b1;
                check(tag, "valid_o on error", int'(valid), 0);
                check(tag, "err_o on error", int'(err), 1);
                if (att == RETRY) begin
                    check(tag, "sclk_o after last failure", int'(sclk), 1);
                end else begin
                    check(tag, "sclk_o repeat starts", int'(sclk), 0);
                    s0 = 1;
                end
            end
        end
        for (int i = 0; i < 6; i++) begin
            step();
            check(tag, "sclk_o idle", int'(sclk), 1);
            check(tag, "valid_o idle", int'(valid), 0);
            check(tag, "err_o idle", int'(err), int'(err_exp));
            check_fields(tag);
        end
    endtask

    task automatic run_inactive(input bit err_exp);
        @(negedge clk);
        mode_r = 4'h0;
        sel_r = 2'd2;
        start_r = 1'b1;
        for (int i = 0; i < 30; i++) begin
            step();
            start_r = 1'b0;
            check("R1", "sclk_o", int'(sclk), 1);
            check("R1", "valid_o", int'(valid), 0);
            check("R1", "err_o", int'(err), int'(err_exp));
            check_fields("R1");
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL R3 watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();
        // reset state (R3 R7)
        check("R3", "sclk_o after reset", int'(sclk), 1);
        check("R7", "valid_o after reset", int'(valid), 0);
        check("R8", "err_o after reset", int'(err), 0);
        check_fields("R7");

        run_inactive(1'b0);                                         // R1
        run_read(13, 1, 'hA5F, 0, 0, -1, 1'b0, "R2 R4 R5 R7");      // 12 turn bits
        run_read(3, 0, 'hD, 0, 0, -1, 1'b0, "R2 R5 R3");            // singleturn only
        run_read(9, 3, 'h1ABCD, 0, 0, -1, 1'b0, "R2 R5 R4");        // split layout
        run_read(15, 3, 'h2DB6E5, 0, 0, -1, 1'b0, "R2 R5 R6");      // longest frame
        run_read(1, 0, 'h2, 0, 0, -1, 1'b0, "R2 R3");               // shortest frame
        run_read(11, 2, 'h5B, 0, 0, 40, 1'b0, "R10 busy start");    // start ignored mid-frame
        run_read(10, 1, 'h2F3C7, 1, 0, -1, 1'b0, "R4 R8 ack");      // bad acknowledge then good
        run_read(14, 0, 'h1C3A5, 0, 3, -1, 1'b0, "R6 R8 end");      // two bad end levels
        run_read(12, 2, 'h7E, 5, 10, -1, 1'b0, "R9 exhausted");     // all attempts fail
        run_inactive(1'b1);                                         // R1 keeps error
        run_read(8, 1, 'h39A5, 0, 0, -1, 1'b1, "R10 clear");        // new start clears error
        run_read(7, 0, 'h6AB5, 0, 0, -1, 1'b0, "R2 R5 R7");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule